// File: doc/BRIEF.md
# Key-Protected 64-bit Watchdog Timer

A 64-bit timer on a small synchronous register bus that serves either as a general-purpose counter with an interrupt, or as a watchdog that can ask for a system reset. The count and the period each occupy two 32-bit registers. The counter advances only on cycles where the timer clock enable is high. In general-purpose mode it raises a one-cycle interrupt when it reaches the period, then either wraps to zero or halts.

Watchdog mode is selected by the timer-mode field. Software must then write two different 16-bit keys, in order, to arm it. Once it is armed, the same pair of keys written in order restarts the count. Any other key value written in that state makes the block request a reset at once. The reset request is also raised when the count reaches the period. Each request is stretched to a fixed number of clock cycles. An armed watchdog cannot be disarmed, and its mode cannot be changed, except through the block's own reset input.

Top module: `keyed_wdt_timer`

## Requirements
- R1: After reset, every register reads zero except offset 0x00, which reads the constant ID parameter. irq_o and wd_rst_o are low.
- R2: Register offsets are as follows. 0x10 holds count bits [31:0] and 0x14 holds count bits [63:32]. 0x18 and 0x1C hold the period in the same split. 0x20 holds the run field in bits [1:0]. 0x24 holds a low-half release in bit 0, a high-half release in bit 1 and a timer mode in bits [3:2]. 0x28 holds the watchdog enable in bit 14 and the key in bits [31:16]. The key always reads as zero. Writes to these offsets read back.
- R3: While a half's release bit is 0, that half reads zero and ignores writes. The counter advances only when both release bits are 1.
- R4: In a general-purpose mode with run field 2 or 3 (continuous), a tick with count equal to period pulses irq_o high for one cycle and reloads the count to zero. Other ticks add one, so a full cycle takes period+1 ticks.
- R5: With run field 1 (one-shot), the matching tick pulses irq_o. The count stays at the period and the run field returns to 0.
- R6: With run field 0, or with tick_i low, the count does not change.
- R7: In mode 2 (watchdog), a write of key 0xA5C6 with bit 14 set enters pre-active. A following write of key 0xDA7E with bit 14 set arms the watchdog. Any other write in pre-active returns to idle, so a later 0xDA7E alone does not arm it.
- R8: While armed, each tick adds one to the count. The tick on which the count equals the period asserts wd_rst_o for exactly 16 cycles and clears the count.
- R9: While armed, a write of key 0xA5C6 followed by a write of key 0xDA7E clears the 64-bit count to zero. No reset request results.
- R10: While armed, a key other than the two valid keys raises wd_rst_o on the cycle after the write. After 0xA5C6 has been written, any key other than 0xDA7E does the same.
- R11: While armed, writes leave the timer-mode field and the enable bit unchanged. The release bits stay writable.
- R12: Timer modes 1 and 3 behave as mode 0: a single 64-bit count, with the carry passing from the low half into the high half.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_i | input | 1 | Register write strobe |
| rd_i | input | 1 | Register read strobe |
| addr_i | input | ADDR_W (6) | Byte address |
| wdata_i | input | DATA_W (32) | Write data |
| rdata_o | output | DATA_W (32) | Read data, combinational, zero when rd_i is low |
| tick_i | input | 1 | Timer clock enable |
| irq_o | output | 1 | General-purpose match pulse |
| wd_rst_o | output | 1 | Stretched system reset request |

## Verification
The bench uses the default 32-bit halves and the 16-cycle request stretch, so the length of the reset request can be counted directly at the pin. It overrides the ID constant so that the identification read is shown to come from the parameter. With 32-bit halves, a preloaded low half of all ones carries into the high half on a single tick. Small periods bring wrap, one-shot stop, watchdog expiry and service within a few ticks.

// File: rtl/kwdt_pkg.sv
package kwdt_pkg;
  typedef enum logic [1:0] {WD_IDLE, WD_PRE, WD_ACT, WD_SVC} wd_state_e;

  localparam logic [1:0] TM_WD64   = 2'd2;
  localparam logic [1:0] RUN_OFF   = 2'd0;
  localparam logic [1:0] RUN_ONCE  = 2'd1;

  localparam int OFF_ID     = 'h00;
  localparam int OFF_CNT_LO = 'h10;
  localparam int OFF_PER_LO = 'h18;
  localparam int OFF_RUN    = 'h20;
  localparam int OFF_GLB    = 'h24;
  localparam int OFF_WDC    = 'h28;

  localparam int WD_EN_BIT = 14;
  localparam int KEY_LSB   = 16;
  localparam logic [15:0] KEY_ARM = 16'hA5C6;
  localparam logic [15:0] KEY_GO  = 16'hDA7E;
endpackage

// File: rtl/kwdt_key_fsm.sv
module kwdt_key_fsm
  import kwdt_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_i,
  input  logic [15:0] key_i,
  input  logic        en_i,
  input  logic        wd_mode_i,
  output logic        armed_o,
  output logic        en_o,
  output logic        svc_clear_o,
  output logic        bad_key_o
);
  wd_state_e state_q, state_d;
  logic en_q;

  always_comb begin
    state_d = state_q;
    if (wr_i) begin
      unique case (state_q)
        WD_IDLE: if (key_i == KEY_ARM && en_i && wd_mode_i) state_d = WD_PRE;
        WD_PRE:  state_d = (key_i == KEY_GO && en_i) ? WD_ACT : WD_IDLE;
        WD_ACT:  if (key_i == KEY_ARM) state_d = WD_SVC;
        WD_SVC:  state_d = WD_ACT;
        default: state_d = WD_IDLE;
      endcase
    end
  end

  assign armed_o     = (state_q == WD_ACT) || (state_q == WD_SVC);
  assign svc_clear_o = wr_i && (state_q == WD_SVC) && (key_i == KEY_GO);
  assign bad_key_o   = wr_i && (((state_q == WD_ACT) && key_i != KEY_ARM && key_i != KEY_GO)
                             || ((state_q == WD_SVC) && key_i != KEY_GO));
  assign en_o = en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= WD_IDLE;
      en_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      if (wr_i && !armed_o) en_q <= en_i;
    end
  end

  assert_armed_sticky_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_o |=> armed_o && $stable(en_o));
  assert_pre_abort_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == WD_PRE) && wr_i && !(key_i == KEY_GO && en_i) |=> state_q == WD_IDLE);
  assert_bad_only_armed_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bad_key_o |-> $past(state_q) != WD_IDLE || state_q != WD_IDLE);
endmodule

// File: rtl/kwdt_counter64.sv
module kwdt_counter64 #(
  parameter int HALF_W     = 32,
  parameter int NUM_HALVES = 2,
  localparam int CNT_W     = HALF_W * NUM_HALVES
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [NUM_HALVES-1:0] rs_i,
  input  logic [NUM_HALVES-1:0] wr_i,
  input  logic [HALF_W-1:0]     wdata_i,
  input  logic                  step_i,
  input  logic                  zero_i,
  output logic [CNT_W-1:0]      cnt_o
);
  logic [CNT_W-1:0] cnt_q, cnt_inc;
  assign cnt_inc = cnt_q + CNT_W'(1);
  assign cnt_o   = cnt_q;

  for (genvar g = 0; g < NUM_HALVES; g++) begin : g_half
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       cnt_q[g*HALF_W +: HALF_W] <= '0;
      else if (!rs_i[g]) cnt_q[g*HALF_W +: HALF_W] <= '0;
      else if (wr_i[g])  cnt_q[g*HALF_W +: HALF_W] <= wdata_i;
      else if (zero_i)   cnt_q[g*HALF_W +: HALF_W] <= '0;
      else if (step_i)   cnt_q[g*HALF_W +: HALF_W] <= cnt_inc[g*HALF_W +: HALF_W];
    end

    assert_half_held_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !rs_i[g] |=> cnt_o[g*HALF_W +: HALF_W] == '0);
  end
endmodule

// File: rtl/kwdt_req_stretch.sv
module kwdt_req_stretch #(
  parameter int HOLD = 16,
  localparam int CW  = $clog2(HOLD + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fire_i,
  output logic req_o
);
  logic [CW-1:0] hold_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            hold_q <= '0;
    else if (fire_i)        hold_q <= CW'(HOLD);
    else if (hold_q != '0)  hold_q <= hold_q - CW'(1);
  end

  assign req_o = (hold_q != '0);

  assert_req_cause_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(req_o) |-> $past(fire_i));
  assert_req_immediate_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_i |=> req_o);
endmodule

// File: rtl/keyed_wdt_timer.sv
module keyed_wdt_timer
  import kwdt_pkg::*;
#(
  parameter int          ADDR_W      = 6,
  parameter int          DATA_W      = 32,
  parameter logic [31:0] ID_VALUE    = 32'h0001_0040,
  parameter int          HOLD_CYCLES = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              tick_i,
  output logic              irq_o,
  output logic              wd_rst_o
);
  localparam int NH    = 2;
  localparam int CNT_W = DATA_W * NH;

  logic [1:0]       run_q, tmode_q, rs_q;
  logic [CNT_W-1:0] per_q, cnt;
  logic [NH-1:0]    wr_cnt, wr_per;
  logic             wr_run, wr_glb, wr_wdc;
  logic             armed, wd_en, svc_clear, bad_key;
  logic             gp_mode, released, gp_run, wd_run, hit;
  logic             gp_expire, wd_expire, step, zero, irq_q;

  assign wr_run = wr_i && addr_i == ADDR_W'(OFF_RUN);
  assign wr_glb = wr_i && addr_i == ADDR_W'(OFF_GLB);
  assign wr_wdc = wr_i && addr_i == ADDR_W'(OFF_WDC);

  for (genvar h = 0; h < NH; h++) begin : g_dec
    assign wr_cnt[h] = wr_i && addr_i == ADDR_W'(OFF_CNT_LO + 4 * h);
    assign wr_per[h] = wr_i && addr_i == ADDR_W'(OFF_PER_LO + 4 * h);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        per_q[h*DATA_W +: DATA_W] <= '0;
      else if (wr_per[h]) per_q[h*DATA_W +: DATA_W] <= wdata_i;
    end
  end

  kwdt_key_fsm u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_i        (wr_wdc),
    .key_i       (wdata_i[KEY_LSB +: 16]),
    .en_i        (wdata_i[WD_EN_BIT]),
    .wd_mode_i   (tmode_q == TM_WD64),
    .armed_o     (armed),
    .en_o        (wd_en),
    .svc_clear_o (svc_clear),
    .bad_key_o   (bad_key)
  );

  // modes 0, 1 and 3 all run as one 64-bit count
  assign gp_mode   = (tmode_q != TM_WD64);
  assign released  = &rs_q;
  assign gp_run    = gp_mode && run_q != RUN_OFF && tick_i && released;
  assign wd_run    = !gp_mode && armed && tick_i && released;
  assign hit       = (cnt == per_q);
  assign gp_expire = gp_run && hit;
  assign wd_expire = wd_run && hit;
  assign step      = (gp_run || wd_run) && !hit;
  assign zero      = (gp_expire && run_q != RUN_ONCE) || wd_expire || svc_clear;

  kwdt_counter64 #(.HALF_W(DATA_W), .NUM_HALVES(NH)) u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .rs_i    (rs_q),
    .wr_i    (wr_cnt),
    .wdata_i (wdata_i),
    .step_i  (step),
    .zero_i  (zero),
    .cnt_o   (cnt)
  );

  kwdt_req_stretch #(.HOLD(HOLD_CYCLES)) u_req (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .fire_i (wd_expire || bad_key),
    .req_o  (wd_rst_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q   <= RUN_OFF;
      tmode_q <= '0;
      rs_q    <= '0;
      irq_q   <= 1'b0;
    end else begin
      irq_q <= gp_expire;
      if (wr_run)                                run_q <= wdata_i[1:0];
      else if (gp_expire && run_q == RUN_ONCE)   run_q <= RUN_OFF;
      if (wr_glb) begin
        rs_q <= wdata_i[1:0];
        if (!armed) tmode_q <= wdata_i[3:2];
      end
    end
  end

  assign irq_o = irq_q;

  always_comb begin
    rdata_o = '0;
    if (rd_i) begin
      unique case (addr_i)
        ADDR_W'(OFF_ID):         rdata_o = DATA_W'(ID_VALUE);
        ADDR_W'(OFF_CNT_LO):     rdata_o = cnt[0 +: DATA_W];
        ADDR_W'(OFF_CNT_LO + 4): rdata_o = cnt[DATA_W +: DATA_W];
        ADDR_W'(OFF_PER_LO):     rdata_o = per_q[0 +: DATA_W];
        ADDR_W'(OFF_PER_LO + 4): rdata_o = per_q[DATA_W +: DATA_W];
        ADDR_W'(OFF_RUN):        rdata_o = DATA_W'(run_q);
        ADDR_W'(OFF_GLB):        rdata_o = DATA_W'({tmode_q, rs_q});
        ADDR_W'(OFF_WDC):        rdata_o = DATA_W'({wd_en, 14'h0});
        default:                 rdata_o = '0;
      endcase
    end
  end

  assert_irq_gp_only_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> $past(tmode_q) != TM_WD64);
  assert_mode_locked_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed && wr_glb |=> tmode_q == $past(tmode_q));
  assert_oneshot_stop_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gp_expire && run_q == RUN_ONCE && !wr_run |=> run_q == RUN_OFF);
  assert_idle_count_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i && !wr_i && !svc_clear && $past(rs_q) == rs_q && released |=> $stable(cnt));
endmodule

// File: tb/keyed_wdt_timer_bench.sv
module keyed_wdt_timer_bench;
  localparam logic [31:0] ID_B = 32'h5A17_0C01;
  logic clk = 0, rst_ni = 0, wr = 0, rd = 0, tick = 0;
  logic [5:0]  addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic irq, wd_rst;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  keyed_wdt_timer #(.ID_VALUE(ID_B)) u_keyed_wdt_timer (
    .clk_i(clk), .rst_ni(rst_ni), .wr_i(wr), .rd_i(rd), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .tick_i(tick), .irq_o(irq), .wd_rst_o(wd_rst));

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_ni = 0; wr = 0; rd = 0; tick = 0;
    repeat (2) @(negedge clk);
    rst_ni = 1;
  endtask

  task automatic wreg(logic [5:0] a, logic [31:0] d);
    @(negedge clk); wr = 1; addr = a; wdata = d;
    @(negedge clk); wr = 0;
  endtask

  task automatic rreg(logic [5:0] a, output logic [31:0] d);
    @(negedge clk); rd = 1; addr = a;
    #1 d = rdata; rd = 0;
  endtask

  task automatic tick_n(int n);
    @(negedge clk); tick = 1;
    repeat (n) @(negedge clk);
    tick = 0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    do_reset();
    rreg(6'h00, d); check("R1 id", d, ID_B);
    for (int a = 'h10; a <= 'h28; a += 4) begin
      rreg(a[5:0], d); check("R1 reg zero", d, 0);
    end
    check("R1 irq", irq, 0);
    check("R1 wd_rst", wd_rst, 0);
  endtask

  task automatic t_regs();
    logic [31:0] d;
    wreg(6'h10, 32'h5); rreg(6'h10, d); check("R3 held half ignores write", d, 0);
    wreg(6'h24, 32'h3);
    wreg(6'h10, 32'h5); rreg(6'h10, d); check("R2 cnt lo", d, 5);
    wreg(6'h14, 32'h9); rreg(6'h14, d); check("R2 cnt hi", d, 9);
    wreg(6'h1C, 32'h77); rreg(6'h1C, d); check("R2 per hi", d, 32'h77);
    wreg(6'h28, 32'h1234_4000); rreg(6'h28, d); check("R2 wd ctl key reads zero", d, 32'h4000);
    wreg(6'h24, 32'h2); @(negedge clk);
    rreg(6'h10, d); check("R3 lo held zero", d, 0);
    rreg(6'h14, d); check("R3 hi kept", d, 9);
    wreg(6'h20, 32'h2); tick_n(3);
    rreg(6'h14, d); check("R3 no count while a half held", d, 9);
    wreg(6'h20, 32'h0); wreg(6'h24, 32'h0); @(negedge clk);
    rreg(6'h14, d); check("R3 hi held zero", d, 0);
    wreg(6'h1C, 32'h0); wreg(6'h28, 32'h0);
  endtask

  task automatic t_periodic();
    logic [31:0] d;
    wreg(6'h24, 32'h3); wreg(6'h18, 32'h3); wreg(6'h10, 0); wreg(6'h14, 0);
    wreg(6'h20, 32'h2);
    tick_n(3);
    rreg(6'h10, d); check("R4 count at period", d, 3);
    check("R4 no irq yet", irq, 0);
    tick_n(1);
    check("R4 irq pulse", irq, 1);
    rreg(6'h10, d); check("R4 reload zero", d, 0);
    @(negedge clk); check("R4 irq one cycle", irq, 0);
    wreg(6'h20, 32'h0); tick_n(5);
    rreg(6'h10, d); check("R6 run off holds", d, 0);
    wreg(6'h20, 32'h2); repeat (5) @(negedge clk);
    rreg(6'h10, d); check("R6 no tick holds", d, 0);
  endtask

  task automatic t_oneshot();
    logic [31:0] d;
    wreg(6'h20, 0); wreg(6'h18, 32'h2); wreg(6'h10, 0);
    wreg(6'h20, 32'h1);
    tick_n(3);
    check("R5 irq", irq, 1);
    rreg(6'h20, d); check("R5 run field cleared", d, 0);
    tick_n(2);
    rreg(6'h10, d); check("R5 count stays at period", d, 2);
  endtask

  task automatic t_carry();
    logic [31:0] d;
    wreg(6'h20, 0); wreg(6'h24, 32'h7);
    wreg(6'h18, 0); wreg(6'h1C, 32'h1); wreg(6'h14, 0); wreg(6'h10, 32'hFFFF_FFFF);
    wreg(6'h20, 32'h2);
    tick_n(1);
    rreg(6'h10, d); check("R12 mode1 lo wraps", d, 0);
    rreg(6'h14, d); check("R12 mode1 carry", d, 1);
    check("R12 no irq", irq, 0);
    tick_n(1);
    check("R12 64-bit match irq", irq, 1);
    rreg(6'h14, d); check("R12 reload hi", d, 0);
    wreg(6'h24, 32'hF); wreg(6'h1C, 32'h5); wreg(6'h10, 32'hFFFF_FFFF);
    tick_n(1);
    rreg(6'h14, d); check("R12 mode3 carry", d, 1);
    wreg(6'h20, 0);
  endtask

  task automatic t_arm_abort();
    logic [31:0] d;
    do_reset();
    wreg(6'h24, 32'hB);
    wreg(6'h28, 32'hA5C6_4000);
    wreg(6'h28, 32'h1234_4000);
    wreg(6'h28, 32'hDA7E_4000);
    check("R7 aborted no reset", wd_rst, 0);
    wreg(6'h24, 32'h3); rreg(6'h24, d); check("R7 not armed mode writable", d, 3);
  endtask

  task automatic t_armed();
    logic [31:0] d;
    int hi;
    do_reset();
    wreg(6'h24, 32'hB); wreg(6'h18, 32'h4);
    wreg(6'h28, 32'hA5C6_4000);
    wreg(6'h28, 32'hDA7E_4000);
    wreg(6'h24, 32'h3); rreg(6'h24, d); check("R11 mode locked", d, 32'hB);
    wreg(6'h28, 32'hDA7E_0000); rreg(6'h28, d); check("R11 enable locked", d, 32'h4000);
    check("R7 armed valid key no reset", wd_rst, 0);
    tick_n(4);
    rreg(6'h10, d); check("R8 armed counts", d, 4);
    check("R8 no early reset", wd_rst, 0);
    wreg(6'h28, 32'hA5C6_0000); wreg(6'h28, 32'hDA7E_0000);
    rreg(6'h10, d); check("R9 service clears", d, 0);
    check("R9 service no reset", wd_rst, 0);
    tick_n(4);
    check("R8 before expiry", wd_rst, 0);
    tick_n(1);
    hi = wd_rst ? 1 : 0;
    repeat (20) begin @(negedge clk); hi += wd_rst ? 1 : 0; end
    check("R8 hold length", hi, 16);
    rreg(6'h10, d); check("R8 count cleared", d, 0);
    wreg(6'h28, 32'h0000_4000);
    check("R10 bad key active", wd_rst, 1);
    repeat (20) @(negedge clk);
    wreg(6'h28, 32'hA5C6_0000);
    check("R10 first key ok", wd_rst, 0);
    wreg(6'h28, 32'hA5C6_0000);
    check("R10 bad key service pending", wd_rst, 1);
  endtask

  initial begin
    t_reset();
    t_regs();
    t_periodic();
    t_oneshot();
    t_carry();
    t_arm_abort();
    t_armed();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule